// File: doc/BRIEF.md
# Three-Channel Reload Timer

Three independent down-counters share one register port and one clock. A fixed divider makes a peripheral tick every fourth clock. Each channel has its own prescaler, which passes one tick out of every 4, 16, 64, 256 or 1024 peripheral ticks. The prescale is chosen by a three-bit code in the channel's control register. On each prescaled tick a running channel decrements its counter. A tick that arrives while the counter is already zero is an underflow. On an underflow the channel loads its constant register, sets a sticky underflow flag and, when enabled, raises its interrupt line.

Software starts and stops each channel through a shared run register. It may rewrite a counter, constant or control register at any time, including while the channel runs. It acknowledges an underflow by writing zero to the flag. The interrupt line of a channel is high exactly while its flag and its interrupt enable are both set.

Top module: `tri_reload_timer`

## Requirements
- R1: Bit n of the run register (address 0, bits [2:0]) runs channel n. While that bit is 0 the channel's counter holds its value.
- R2: The peripheral tick occurs once every 4 clocks. A running channel with prescale code c in 0..4 decrements once every 4^(c+1) peripheral ticks. Its underflow period is therefore (K+1)*4^(c+1)*4 clocks, where K is the constant value.
- R3: Prescale codes 5, 6 and 7 are reserved, and a channel holding one of them does not count.
- R4: A tick that finds the counter at 0 loads the counter from the constant register instead of wrapping, and sets the underflow flag (control bit 8).
- R5: Interrupt line n is a register that goes high one clock after the flag and the enable (control bit 5) of channel n are both set. It goes low one clock after a write that clears either bit.
- R6: Writing 0 to control bit 8 clears the flag. Writing 1 there leaves it unchanged. An underflow in the same clock as a clearing write leaves the flag set.
- R7: Writes to the counter or the control register take effect on the next clock while the channel runs. The prescaler restarts only when the written code differs from the current one.
- R8: A read returns data on bus_rdata one clock after the read strobe. A counter read gives the live counter value.
- R9: Register map: channel n uses address 4+4n for the constant, 5+4n for the counter and 6+4n for the control register. Control reads return the code in bits [2:0], the enable in bit 5 and the flag in bit 8, with every other bit 0. Unmapped addresses read 0.
- R10: After reset every register reads 0 and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read strobe |
| irq | output | 3 | Per-channel underflow interrupt |

## Verification
On every clock the assertions check several things. A stopped counter holds still. A reserved code yields no count ticks. A non-zero counter steps down by exactly one per tick. An underflow reloads the constant and sets the flag. An interrupt line is never high without both flag and enable, and peripheral ticks are never adjacent. Only the bench scenarios show the exact underflow periods across codes and constants. They also show the write-one-ignored rule for the flag, the independence of the channels, the live counter readback and the register map as seen over the bus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W     = 32;
  localparam int FLAG_BIT   = 8;
  localparam int IE_BIT     = 5;
  localparam int CODE_W     = 3;
  localparam int MAX_CODE   = 4;
  localparam int PRESC_W    = 10;

  // number of peripheral ticks per count tick for a valid code
  function automatic logic [PRESC_W:0] presc_len(input logic [CODE_W-1:0] code);
    return (PRESC_W+1)'(4) << (2 * code);
  endfunction

  function automatic logic code_ok(input logic [CODE_W-1:0] code);
    return int'(code) <= MAX_CODE;
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= (int'(cnt_q) == DIV-1) ? '0 : cnt_q + 1'b1;
      tick_o <= (int'(cnt_q) == DIV-1);
    end
  end

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic              ptick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PRESC_W:0] pc_q;
  logic [PRESC_W:0] last;
  logic             valid;

  always_comb begin
    valid  = code_ok(code_i);
    last   = presc_len(code_i) - 1'b1;
    tick_o = run_i && valid && ptick_i && !restart_i && (pc_q == last);
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i || !valid) begin
      pc_q <= '0;
    end else if (ptick_i) begin
      pc_q <= (pc_q == last) ? '0 : pc_q + 1'b1;
    end
  end

  p_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(code_i) > MAX_CODE) |-> !tick_o);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              const_we,
  input  logic              cnt_we,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  const_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CODE_W-1:0] code_o,
  output logic              ie_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic underflow;
  logic flag_d;
  logic ie_d;

  always_comb begin
    underflow = tick_i && (cnt_o == '0) && !cnt_we;
    flag_d    = (ctrl_we ? (flag_o & wdata[FLAG_BIT]) : flag_o) | underflow;
    ie_d      = ctrl_we ? wdata[IE_BIT] : ie_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      const_o <= '0;
      cnt_o   <= '0;
      code_o  <= '0;
      ie_o    <= 1'b0;
      flag_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (const_we) const_o <= wdata[CNT_W-1:0];
      if (cnt_we)        cnt_o <= wdata[CNT_W-1:0];
      else if (underflow) cnt_o <= const_o;
      else if (tick_i)    cnt_o <= cnt_o - 1'b1;
      if (ctrl_we) code_o <= wdata[CODE_W-1:0];
      ie_o   <= ie_d;
      flag_o <= flag_d;
      irq_o  <= flag_d & ie_d;
    end
  end

  p_freeze_r1: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !cnt_we) |=> $stable(cnt_o));
  p_decrement_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !cnt_we && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !cnt_we && !const_we && cnt_o == '0) |=> (cnt_o == $past(const_o)) && flag_o);
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_o && ie_o));
endmodule

// File: rtl/tri_reload_timer.sv
module tri_reload_timer
  import tmr_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CNT_W  = 32,
  parameter int PDIV   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int RUN_ADDR = 0;

  logic              ptick;
  logic [NCH-1:0]    run_q;
  logic              wr;
  logic [CNT_W-1:0]  const_a [NCH];
  logic [CNT_W-1:0]  cnt_a   [NCH];
  logic [CODE_W-1:0] code_a  [NCH];
  logic [NCH-1:0]    ie_a;
  logic [NCH-1:0]    flag_a;
  logic [DATA_W-1:0] rd_mux;

  assign wr = bus_sel && bus_we;

  tmr_tick_gen #(.DIV(PDIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (ptick)
  );

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (wr && int'(bus_addr) == RUN_ADDR) run_q <= bus_wdata[NCH-1:0];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic const_we, cnt_we, ctrl_we, restart, ctick;

    assign const_we = wr && int'(bus_addr) == 4*(n+1);
    assign cnt_we   = wr && int'(bus_addr) == 4*(n+1) + 1;
    assign ctrl_we  = wr && int'(bus_addr) == 4*(n+1) + 2;
    assign restart  = ctrl_we && (bus_wdata[CODE_W-1:0] != code_a[n]);

    tmr_prescaler u_presc (
      .clk       (clk),
      .rst       (rst),
      .run_i     (run_q[n]),
      .restart_i (restart),
      .ptick_i   (ptick),
      .code_i    (code_a[n]),
      .tick_o    (ctick)
    );

    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .run_i    (run_q[n]),
      .tick_i   (ctick),
      .const_we (const_we),
      .cnt_we   (cnt_we),
      .ctrl_we  (ctrl_we),
      .wdata    (bus_wdata),
      .const_o  (const_a[n]),
      .cnt_o    (cnt_a[n]),
      .code_o   (code_a[n]),
      .ie_o     (ie_a[n]),
      .flag_o   (flag_a[n]),
      .irq_o    (irq[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (int'(bus_addr) == RUN_ADDR) rd_mux = DATA_W'(run_q);
    for (int n = 0; n < NCH; n++) begin
      if (int'(bus_addr) == 4*(n+1))     rd_mux = DATA_W'(const_a[n]);
      if (int'(bus_addr) == 4*(n+1) + 1) rd_mux = DATA_W'(cnt_a[n]);
      if (int'(bus_addr) == 4*(n+1) + 2)
        rd_mux = (DATA_W'(flag_a[n]) << FLAG_BIT) | (DATA_W'(ie_a[n]) << IE_BIT)
               | DATA_W'(code_a[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/tri_reload_timer_bench.sv
module tri_reload_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tri_reload_timer u_tri_reload_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {code, constant, expected period in clocks}
  localparam logic [66:0] VEC [6] = '{
    {3'd0, 32'd3, 32'd64},   {3'd1, 32'd1, 32'd128}, {3'd2, 32'd0, 32'd256},
    {3'd0, 32'd0, 32'd16},   {3'd1, 32'd4, 32'd320}, {3'd3, 32'd0, 32'd1024}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 4'(a);
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int ch, output int t);
    t = -1;
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk);
      #1;
      if (irq[ch]) begin t = cyc; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int t1, t2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R10 reset state, R9 map
    check("R10 irq", 32'(irq), 0);
    for (int a = 0; a < 16; a++) begin
      rd(a, d);
      check("R10 reset read", d, 0);
    end

    // R2/R4/R5/R6 periods from the vector table on channel 0
    foreach (VEC[i]) begin
      wr(0, 0);
      wr(6, 32'h20 | 32'(VEC[i][66:64]));
      wr(4, VEC[i][63:32]);
      wr(5, VEC[i][63:32]);
      wr(0, 1);
      wait_irq(0, t1);
      wr(6, 32'h20 | 32'(VEC[i][66:64]));      // clear flag
      check("R5 irq withdrawn", 32'(irq[0]), 0);
      wait_irq(0, t2);
      check("R2 period", 32'(t2 - t1), VEC[i][31:0]);
      rd(6, d);
      check("R4 flag set", d, 32'h120 | 32'(VEC[i][66:64]));
    end

    // R6 writing 1 leaves flag; R5 clearing enable drops irq
    wr(6, 32'h100);
    check("R5 irq off with ie=0", 32'(irq[0]), 0);
    rd(6, d);
    check("R6 flag kept on write 1", d, 32'h100);
    wr(6, 32'h000);
    rd(6, d);
    check("R6 flag cleared", d, 0);

    // R8 live counter, R1 freeze
    wr(0, 0);
    wr(4, 32'd1000);
    wr(5, 32'd1000);
    wr(0, 1);
    repeat (50) @(posedge clk);
    rd(5, d);
    repeat (158) @(posedge clk);
    rd(5, d2);
    check("R8 live count delta", d - d2, 32'd10);
    wr(0, 0);
    rd(5, d);
    repeat (300) @(posedge clk);
    rd(5, d2);
    check("R1 frozen", d2, d);

    // R7 counter write while running, R4 reload value
    wr(0, 1);
    wr(4, 32'd7);
    wr(5, 32'd0);
    rd(5, d);
    check("R7 count written", d, 0);
    repeat (20) @(posedge clk);
    rd(5, d);
    check("R4 reload", d, 32'd7);

    // R7 control change while running: code 1 -> slower rate
    wr(4, 32'd500);
    wr(5, 32'd500);
    wr(6, 32'd1);
    repeat (20) @(posedge clk);
    rd(5, d);
    repeat (638) @(posedge clk);
    rd(5, d2);
    check("R7 new rate", d - d2, 32'd10);

    // R3 reserved code
    wr(6, 32'd5);
    wr(5, 32'd10);
    repeat (2000) @(posedge clk);
    rd(5, d);
    check("R3 no count", d, 32'd10);

    // R1 independence: channel 2 runs, channel 1 stays
    wr(0, 0);
    wr(9, 32'd40);
    wr(13, 32'd0);
    wr(14, 32'h20);
    wr(0, 3'b100);
    wait_irq(2, t1);
    check("R1 ch2 irq", 32'(t1 >= 0), 1);
    check("R1 other irqs", 32'(irq[1:0]), 0);
    rd(9, d);
    check("R1 ch1 stopped", d, 32'd40);
    rd(0, d);
    check("R9 run readback", d, 32'h4);
    rd(3, d);
    check("R9 unmapped", d, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule